// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external serial master read and write a bank of 8-bit registers. The serial clock, the active-low chip select and the data input arrive asynchronously. Each one passes through a synchronizer into the system clock domain, and edges of the serial clock are found there. The first byte of every transaction is a command. Its top bit picks the direction (0 write, 1 read). The next bit picks whether the address steps forward after each data byte. The low six bits carry the register address. Any number of data bytes follow, eight serial clock pulses each.

The serial timing idles high. Input bits are captured on the rising serial clock edge, and read data changes on the falling edge. Both address and data travel MSB first. The read data leaves on one data output. Two output enables then decide which pad carries it: a separate output pin (4-wire mode) or the shared data line (3-wire mode). A mode input from the owning control register selects between them.

The register bank sees three things. The first is a one-cycle write strobe with address and data. The second is a one-cycle read strobe, raised only when the first bit of a read byte is actually needed, so a clear-on-read side effect is never triggered by a prefetch. The third is a read-data input. The bank returns that data combinationally from the address in the strobe cycle. There is no back-pressure: the bank must accept a strobe in any cycle.

Top module: `spi_regport`

## Requirements
- R1: A command byte with bit 7 = 0 starts a write. Bits 5:0 give the address, MSB first. Each following group of 8 rising serial clock edges produces exactly one write strobe carrying that byte, MSB first.
- R2: A command byte with bit 7 = 1 starts a read. Each data byte taken from the bank is presented MSB first. A bit changes after a falling serial clock edge and holds through the next rising edge.
- R3: With command bit 6 = 1, the address used for each further data byte is one more than the previous address, wrapping from 63 to 0.
- R4: With command bit 6 = 0, every data byte in the transaction uses the command's address.
- R5: If chip select rises before a byte completes, that partial byte is discarded with no write. The next transaction starts again with a command byte.
- R6: The read strobe fires exactly once per read data byte, on the first falling serial clock edge of that byte. No read strobe fires when chip select rises directly after the command byte.
- R7: While a read drives data, only the separate-output enable is high in 4-wire mode (mode input 0), and only the shared-line enable is high in 3-wire mode (mode input 1).
- R8: Both output enables are low whenever chip select is high (after the synchronizer delay) and throughout write transactions.
- R9: After reset, both strobes and both output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the master, idle high |
| csn_i | input | 1 | Chip select, active low |
| sdi_i | input | 1 | Serial data in (the shared line in 3-wire mode) |
| three_wire_i | input | 1 | Mode bit: 0 separate output pin, 1 shared data line |
| dout_o | output | 1 | Serial read data for whichever pad is enabled |
| sdo_oe_o | output | 1 | Drive enable of the separate output pin |
| sdio_oe_o | output | 1 | Drive enable of the shared data line |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_rd_o | output | 1 | One-cycle register read request |
| reg_addr_o | output | 6 | Register address for either strobe |
| reg_wdata_o | output | 8 | Write data |
| reg_rdata_i | input | 8 | Read data returned by the bank for reg_addr_o |

## Verification
The hardest case to reach from the ports is a transaction cut short by chip select. It can be cut inside the command, inside a data byte, or exactly between the command and the first falling edge of a read. In the last case the read strobe must stay silent. The bench reaches these cases by sending truncated bit counts before raising chip select. It then proves that nothing was written by reading the untouched address back through a full transaction. A burst that starts at address 62 covers the wrap from 63 to 0 in both directions.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  typedef enum logic [1:0] {
    PH_CMD   = 2'd0,
    PH_WRITE = 2'd1,
    PH_READ  = 2'd2
  } phase_e;

  localparam int CMD_DIR_BIT = 7;
  localparam int CMD_INC_BIT = 6;
endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= async_i;
      else             stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_regport_rx.sv
module spi_regport_rx #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rise,
  input  logic              din,
  output logic [CNT_W-1:0]  bit_idx,
  output logic              byte_done,
  output logic [DATA_W-1:0] byte_val
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (rise) begin
      sr_q  <= {sr_q[DATA_W-2:0], din};
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign bit_idx   = cnt_q;
  assign byte_done = rise && (cnt_q == LAST);
  assign byte_val  = {sr_q[DATA_W-2:0], din};
endmodule

// File: rtl/spi_regport_tx.sv
module spi_regport_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift,
  output logic              dout,
  output logic              drive
);
  logic [DATA_W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      dout  <= 1'b0;
      drive <= 1'b0;
    end else if (clear) begin
      drive <= 1'b0;
    end else if (load) begin
      dout  <= load_val[DATA_W-1];
      sr_q  <= {load_val[DATA_W-2:0], 1'b0};
      drive <= 1'b1;
    end else if (shift) begin
      dout  <= sr_q[DATA_W-1];
      sr_q  <= {sr_q[DATA_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              sdi_i,
  input  logic              three_wire_i,
  output logic              dout_o,
  output logic              sdo_oe_o,
  output logic              sdio_oe_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam int CNT_W = $clog2(DATA_W);

  // Synchronized pins: {sclk, csn, sdi}; clock and select idle high.
  logic [2:0] pins_s;
  logic       s_sclk, s_csn, s_sdi;

  spi_regport_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b110)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({sclk_i, csn_i, sdi_i}),
    .sync_o (pins_s)
  );

  assign {s_sclk, s_csn, s_sdi} = pins_s;

  logic sclk_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b1;
    else        sclk_q <= s_sclk;
  end

  logic cs_idle, rise, fall;
  assign cs_idle = s_csn;
  assign rise    = !cs_idle && s_sclk && !sclk_q;
  assign fall    = !cs_idle && !s_sclk && sclk_q;

  logic [CNT_W-1:0]  bit_idx;
  logic              byte_done;
  logic [DATA_W-1:0] byte_val;

  spi_regport_rx #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cs_idle),
    .rise     (rise),
    .din      (s_sdi),
    .bit_idx  (bit_idx),
    .byte_done(byte_done),
    .byte_val (byte_val)
  );

  phase_e            phase_q;
  logic [ADDR_W-1:0] addr_q;
  logic              inc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      addr_q  <= '0;
      inc_q   <= 1'b0;
    end else if (cs_idle) begin
      phase_q <= PH_CMD;
    end else if (byte_done) begin
      if (phase_q == PH_CMD) begin
        phase_q <= byte_val[CMD_DIR_BIT] ? PH_READ : PH_WRITE;
        inc_q   <= byte_val[CMD_INC_BIT];
        addr_q  <= byte_val[ADDR_W-1:0];
      end else if (inc_q) begin
        addr_q  <= addr_q + 1'b1;
      end
    end
  end

  logic rd_start, rd_shift, drive;
  assign rd_start = fall && (phase_q == PH_READ) && (bit_idx == '0);
  assign rd_shift = fall && (phase_q == PH_READ) && (bit_idx != '0);

  spi_regport_tx #(.DATA_W(DATA_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (cs_idle),
    .load    (rd_start),
    .load_val(reg_rdata_i),
    .shift   (rd_shift),
    .dout    (dout_o),
    .drive   (drive)
  );

  assign sdo_oe_o    = drive && !three_wire_i;
  assign sdio_oe_o   = drive && three_wire_i;
  assign reg_wr_o    = byte_done && (phase_q == PH_WRITE);
  assign reg_rd_o    = rd_start;
  assign reg_addr_o  = addr_q;
  assign reg_wdata_o = byte_val;
endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_idle,
  input logic              inc_q,
  input logic              reg_wr_o,
  input logic              reg_rd_o,
  input logic [ADDR_W-1:0] reg_addr_o,
  input logic              sdo_oe_o,
  input logic              sdio_oe_o
);
  a_r1_wr_rd_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_o && reg_rd_o));

  a_r3_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_o && inc_q) |=> (reg_addr_o == ADDR_W'($past(reg_addr_o) + 1'b1)));

  a_r4_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_o && !inc_q) |=> $stable(reg_addr_o));

  a_r5_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |-> (!reg_wr_o && !reg_rd_o));

  a_r6_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_o |=> !reg_rd_o);

  a_r7_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
    !(sdo_oe_o && sdio_oe_o));

  a_r8_idle_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> !(sdo_oe_o || sdio_oe_o));
endmodule

bind spi_regport spi_regport_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_idle   (cs_idle),
  .inc_q     (inc_q),
  .reg_wr_o  (reg_wr_o),
  .reg_rd_o  (reg_rd_o),
  .reg_addr_o(reg_addr_o),
  .sdo_oe_o  (sdo_oe_o),
  .sdio_oe_o (sdio_oe_o)
);

// File: tb/spi_regport_test.sv
module spi_regport_test;
  localparam int HALF = 8;
  localparam int NV   = 8;

  typedef struct packed {
    logic        tw;
    logic [7:0]  cmd;
    logic [1:0]  n;
    logic [23:0] data;
  } vec_t;

  // mode, command, byte count, data bytes (first byte in the top bits)
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h05, 2'd1, 24'hA50000},
    '{1'b0, 8'h85, 2'd1, 24'h000000},
    '{1'b0, 8'h7E, 2'd3, 24'h112233},
    '{1'b0, 8'hFE, 2'd3, 24'h000000},
    '{1'b0, 8'h10, 2'd3, 24'h010203},
    '{1'b1, 8'h90, 2'd2, 24'h000000},
    '{1'b1, 8'h20, 2'd1, 24'h5A0000},
    '{1'b0, 8'hE0, 2'd2, 24'h000000}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic sclk = 1'b1, csn = 1'b1, sdi = 1'b0, three_wire = 1'b0;
  logic dout, sdo_oe, sdio_oe, reg_wr, reg_rd;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  spi_regport uut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi),
    .three_wire_i(three_wire), .dout_o(dout), .sdo_oe_o(sdo_oe),
    .sdio_oe_o(sdio_oe), .reg_wr_o(reg_wr), .reg_rd_o(reg_rd),
    .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata)
  );

  // Register bank model and strobe logs
  logic [7:0] bank [64];
  logic [7:0] mirror [64];
  int wr_cnt = 0, rd_cnt = 0;
  logic [5:0] wr_a [8];
  logic [7:0] wr_d [8];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) bank[i] <= 8'(i) ^ 8'hC3;
    end else begin
      if (reg_wr) begin
        bank[reg_addr]   <= reg_wdata;
        wr_a[wr_cnt % 8] <= reg_addr;
        wr_d[wr_cnt % 8] <= reg_wdata;
        wr_cnt           <= wr_cnt + 1;
      end
      if (reg_rd) rd_cnt <= rd_cnt + 1;
    end
  end
  assign reg_rdata = bank[reg_addr];

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, input int nbits,
                       output logic [7:0] rx, output logic oe_m, output logic oe_s);
    rx = '0; oe_m = 1'b0; oe_s = 1'b0;
    for (int i = 7; i >= 8 - nbits; i--) begin
      sclk = 1'b0; sdi = tx[i];
      tick(HALF);
      rx[i] = dout; oe_m = sdo_oe; oe_s = sdio_oe;
      sclk = 1'b1;
      tick(HALF);
    end
  endtask

  task automatic cs_start();
    csn = 1'b0;
    tick(HALF);
  endtask

  task automatic cs_end();
    csn = 1'b1;
    tick(2 * HALF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx, d;
    logic om, os;
    logic [5:0] a;
    int wb, rb;
    for (int i = 0; i < 64; i++) mirror[i] = 8'(i) ^ 8'hC3;
    tick(4);
    rst_n = 1'b1;
    tick(4);

    // R9: reset state
    check(!sdo_oe && !sdio_oe, "R9", "enables after reset", {sdo_oe, sdio_oe}, 0);
    check(!reg_wr && !reg_rd && wr_cnt == 0, "R9", "strobes after reset", wr_cnt, 0);

    for (int v = 0; v < NV; v++) begin
      vec_t t = VECS[v];
      three_wire = t.tw;
      tick(4);
      wb = wr_cnt; rb = rd_cnt;
      cs_start();
      xbyte(t.cmd, 8, rx, om, os);
      for (int k = 0; k < int'(t.n); k++) begin
        d = t.data[23 - 8*k -: 8];
        a = t.cmd[6] ? 6'(t.cmd[5:0] + 6'(k)) : t.cmd[5:0];
        xbyte(t.cmd[7] ? 8'h00 : d, 8, rx, om, os);
        if (t.cmd[7]) begin
          check(rx == mirror[a], t.cmd[6] ? "R3" : "R4", "read byte addr", rx, mirror[a]);
          check(rx == mirror[a], "R2", "read data", rx, mirror[a]);
          check(om == !t.tw && os == t.tw, "R7", "drive enables", {om, os}, {!t.tw, t.tw});
        end else begin
          mirror[a] = d;
          check(!om && !os, "R8", "enables during write", {om, os}, 0);
        end
      end
      cs_end();
      if (t.cmd[7]) begin
        check(rd_cnt - rb == int'(t.n), "R6", "read strobes", rd_cnt - rb, t.n);
        check(wr_cnt == wb, "R2", "no write on read", wr_cnt - wb, 0);
      end else begin
        check(wr_cnt - wb == int'(t.n), "R1", "write strobes", wr_cnt - wb, t.n);
        for (int k = 0; k < int'(t.n); k++) begin
          a = t.cmd[6] ? 6'(t.cmd[5:0] + 6'(k)) : t.cmd[5:0];
          check(wr_a[(wb + k) % 8] == a, t.cmd[6] ? "R3" : "R4", "write addr",
                wr_a[(wb + k) % 8], a);
          check(wr_d[(wb + k) % 8] == t.data[23 - 8*k -: 8], "R1", "write data",
                wr_d[(wb + k) % 8], t.data[23 - 8*k -: 8]);
        end
        check(rd_cnt == rb, "R6", "no read strobe on write", rd_cnt - rb, 0);
      end
      check(!sdo_oe && !sdio_oe, "R8", "enables with select high", {sdo_oe, sdio_oe}, 0);
    end

    // R5: abort inside a data byte
    three_wire = 1'b0;
    wb = wr_cnt;
    cs_start();
    xbyte(8'h0A, 8, rx, om, os);
    xbyte(8'hFF, 4, rx, om, os);
    cs_end();
    check(wr_cnt == wb, "R5", "partial byte write count", wr_cnt - wb, 0);
    cs_start();
    xbyte(8'h8A, 8, rx, om, os);
    xbyte(8'h00, 8, rx, om, os);
    cs_end();
    check(rx == mirror[6'h0A], "R5", "aborted addr unchanged", rx, mirror[6'h0A]);

    // R5: abort inside the command, then a full write
    wb = wr_cnt;
    cs_start();
    xbyte(8'hC7, 5, rx, om, os);
    cs_end();
    cs_start();
    xbyte(8'h2A, 8, rx, om, os);
    xbyte(8'h77, 8, rx, om, os);
    cs_end();
    mirror[6'h2A] = 8'h77;
    check(wr_cnt - wb == 1, "R5", "write after command abort", wr_cnt - wb, 1);
    check(wr_a[wb % 8] == 6'h2A && wr_d[wb % 8] == 8'h77, "R5", "fresh command decode",
          {wr_a[wb % 8], wr_d[wb % 8]}, {6'h2A, 8'h77});

    // R6: read command followed directly by select high
    rb = rd_cnt;
    cs_start();
    xbyte(8'h85, 8, rx, om, os);
    cs_end();
    check(rd_cnt == rb, "R6", "no strobe without falling edge", rd_cnt - rb, 0);
    check(!sdo_oe && !sdio_oe, "R8", "enables after aborted read", {sdo_oe, sdio_oe}, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule